// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the host-side master of the MII management interface. The host supplies a PHY address, a register address, sixteen bits of write data and a read/write choice, then pulses a start strobe. The block derives the MDC clock from the host clock and sends one complete management frame on MDIO. On a read, it collects the sixteen bits the PHY returns and presents them with a one-cycle done pulse.

The MDIO pin is split into a data output, an output enable and a data input. The tri-state buffer sits outside the block. A link-fail flag is updated as a side effect whenever a read of the PHY status register (register address 1) completes. The flag takes the inverse of the link bit, which is bit 2 of the returned value.

Top module: `mdio_master`

## Requirements
- R1: While and right after reset, `busy`, `mdc`, `mdoEn`, `mdoOut`, `rdDone`, `linkFail` and `rdData` are all zero.
- R2: MDC has a period of `clkDiv` host cycles (even, at least 4), with equal high and low halves. A frame lasts exactly 64 MDC periods, so `busy` stays high for 64*`clkDiv` cycles. MDC is low whenever the block is idle.
- R3: A frame begins with 32 ones, followed by the start pattern 0 then 1.
- R4: The start pattern is followed by the opcode: 0,1 for a write and 1,0 for a read. Next come the 5-bit PHY address and then the 5-bit register address, each most significant bit first.
- R5: On a write, the block drives the turnaround as 1 then 0, then the 16 data bits most significant bit first. `mdoEn` stays high for all 64 bits.
- R6: On a read, `mdoEn` is high for the first 46 bits and low from the first turnaround bit through the last data bit.
- R7: On a read, MDIO is sampled in the host cycle just before each falling edge of MDC during the data bits. The 16 samples are assembled most significant bit first into `rdData`, which updates together with a `rdDone` pulse exactly one cycle wide as the frame ends. A write gives no `rdDone` and leaves `rdData` unchanged.
- R8: A start strobe while `busy` is high is ignored. The frame in progress keeps its fields, direction and length, and no second frame follows.
- R9: When a read of register address 1 completes, `linkFail` becomes the inverse of bit 2 of the received value. Reads of other registers and all writes leave `linkFail` unchanged.
- R10: `mdoOut` and `mdoEn` change only at falling edges of MDC, so they are stable while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Asynchronous reset, active high |
| clkDiv | input | DIV_W | MDC divisor in host cycles, even and at least 4, sampled at start |
| startReq | input | 1 | Start strobe, taken only while idle |
| isRead | input | 1 | 1 selects a read frame, 0 a write frame |
| phyAddr | input | 5 | PHY address |
| regAddr | input | 5 | Register address within the PHY |
| wrData | input | 16 | Data for a write frame |
| busy | output | 1 | High while a frame is in progress |
| rdDone | output | 1 | One-cycle pulse when a read completes |
| rdData | output | 16 | Last value read from the PHY |
| linkFail | output | 1 | Inverse of the link bit from the last status-register read |
| mdc | output | 1 | Management clock |
| mdoOut | output | 1 | MDIO output data |
| mdoEn | output | 1 | MDIO output enable |
| mdiIn | input | 1 | MDIO input data |

## Verification
The bench acts as the PHY. It captures MDIO on every rising MDC edge and drives read data one half period before the master samples it. This catches an off-by-one in the bit counter as a frame shifted by one bit or a 63- or 65-period frame. It also catches a turnaround that keeps driving during a read. Status-register reads are run with the link bit both set and clear, then followed by reads of other registers and by writes. A design that latched the wrong bit, or updated the flag on every frame, shows the wrong `linkFail`. A start strobe is also sent in the middle of a frame with every field inverted. A design that accepted it would change the frame's bits, its length or its direction.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [5:0] PRE_END    = 6'd32;  // first bit after the preamble
  localparam logic [5:0] TA_FIRST   = 6'd46;  // first turnaround bit
  localparam logic [5:0] LAST_BIT   = 6'd63;
  localparam logic [4:0] STATUS_REG = 5'd1;

  typedef struct packed {
    logic load;      // capture the frame fields
    logic readReq;   // direction requested at load
    logic shift;     // advance the frame register at a falling MDC edge
    logic last;      // final falling edge of the frame
    logic preamble;  // preamble bits in progress
    logic drive;     // master owns MDIO
    logic readOp;    // direction of the frame in progress
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic             isRead,
  input  logic [DIV_W-1:0] clkDiv,
  output logic             busy,
  output logic             mdc,
  output logic             rdDone,
  output mdioStrobe_t      st
);
  logic [DIV_W-1:0] divHalf;
  logic [DIV_W-1:0] divCnt;
  logic [5:0]       bitCnt;
  logic             rdOp;
  logic             accept;
  logic             tick;
  logic             fallEn;

  assign accept = startReq && !busy;
  assign tick   = busy && (divCnt == divHalf - 1'b1);
  assign fallEn = tick && mdc;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      busy    <= 1'b0;
      mdc     <= 1'b0;
      rdDone  <= 1'b0;
      rdOp    <= 1'b0;
      divHalf <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
    end else begin
      rdDone <= fallEn && (bitCnt == LAST_BIT) && rdOp;
      if (accept) begin
        busy    <= 1'b1;
        mdc     <= 1'b0;
        rdOp    <= isRead;
        divHalf <= clkDiv >> 1;
        divCnt  <= '0;
        bitCnt  <= '0;
      end else if (busy) begin
        if (tick) begin
          divCnt <= '0;
          mdc    <= ~mdc;
          if (mdc) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) busy <= 1'b0;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    st.load     = accept;
    st.readReq  = isRead;
    st.shift    = fallEn && (bitCnt >= PRE_END);
    st.last     = fallEn && (bitCnt == LAST_BIT);
    st.preamble = bitCnt < PRE_END;
    st.drive    = busy && (!rdOp || bitCnt < TA_FIRST);
    st.readOp   = rdOp;
  end

  // R2
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R8
  op_stable_chk: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(rdOp) && $stable(divHalf));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rdDone |=> !rdDone);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rdDone |-> !busy);
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  mdioStrobe_t st,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  input  logic        mdiIn,
  output logic        mdoOut,
  output logic        mdoEn,
  output logic [15:0] rdData,
  output logic        linkFail
);
  logic [31:0] frameSr;
  logic [4:0]  regHeld;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      frameSr  <= '0;
      regHeld  <= '0;
      rdData   <= '0;
      linkFail <= 1'b0;
    end else if (st.load) begin
      frameSr <= {2'b01, st.readReq, ~st.readReq, phyAddr, regAddr, 2'b10, wrData};
      regHeld <= regAddr;
    end else if (st.shift) begin
      frameSr <= {frameSr[30:0], mdiIn};
      if (st.last && st.readOp) begin
        rdData <= {frameSr[14:0], mdiIn};
        // bit 2 of the finished word is still at position 1 before this shift
        if (regHeld == STATUS_REG) linkFail <= ~frameSr[1];
      end
    end
  end

  assign mdoEn  = st.drive;
  assign mdoOut = st.drive & (st.preamble | frameSr[31]);

  // R9
  link_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !st.last |=> $stable(linkFail));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(st.last && st.readOp) |=> $stable(rdData));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             startReq,
  input  logic             isRead,
  input  logic [4:0]       phyAddr,
  input  logic [4:0]       regAddr,
  input  logic [15:0]      wrData,
  output logic             busy,
  output logic             rdDone,
  output logic [15:0]      rdData,
  output logic             linkFail,
  output logic             mdc,
  output logic             mdoOut,
  output logic             mdoEn,
  input  logic             mdiIn
);
  mdioStrobe_t st;

  mdio_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rst(rst), .startReq(startReq), .isRead(isRead),
    .clkDiv(clkDiv), .busy(busy), .mdc(mdc), .rdDone(rdDone), .st(st)
  );

  mdio_dp uDp (
    .clk(clk), .rst(rst), .st(st), .phyAddr(phyAddr), .regAddr(regAddr),
    .wrData(wrData), .mdiIn(mdiIn), .mdoOut(mdoOut), .mdoEn(mdoEn),
    .rdData(rdData), .linkFail(linkFail)
  );

  // R10
  mdo_stable_chk: assert property (@(posedge clk) disable iff (rst)
    mdc && $past(mdc) |-> $stable(mdoOut) && $stable(mdoEn));
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst;
  logic [DIV_W-1:0] clkDiv;
  logic             startReq, isRead;
  logic [4:0]       phyAddr, regAddr;
  logic [15:0]      wrData;
  logic             busy, rdDone, linkFail, mdc, mdoOut, mdoEn;
  logic [15:0]      rdData;
  logic             mdiIn;

  mdio_master #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst(rst), .clkDiv(clkDiv), .startReq(startReq), .isRead(isRead),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData), .busy(busy),
    .rdDone(rdDone), .rdData(rdData), .linkFail(linkFail), .mdc(mdc),
    .mdoOut(mdoOut), .mdoEn(mdoEn), .mdiIn(mdiIn)
  );

  int checks = 0;
  int errors = 0;
  int riseCnt = 99;
  int highCnt = 0;
  logic [63:0] outB, enB;
  logic        curRead = 1'b0;
  logic [15:0] phyVal = '0;
  logic [15:0] lastRd = '0;
  logic        expLink = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] expFrame(input bit rd, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, d};
  endfunction

  // PHY model: capture on rising MDC, present read data for the master's sample
  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      outB[63-riseCnt] = mdoOut;
      enB[63-riseCnt]  = mdoEn;
      if (curRead && riseCnt >= 48) mdiIn = phyVal[63-riseCnt];
      else if (curRead && riseCnt == 47) mdiIn = 1'b0;
      else mdiIn = 1'b1;
    end
    riseCnt++;
  end

  always @(negedge clk) if (mdc) highCnt++;

  task automatic runFrame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [15:0] pv,
                          input int div, input bit interject);
    int n;
    int dones;
    logic [15:0] got;
    logic [63:0] ef;
    ef = expFrame(rd, pa, ra, wd);
    @(negedge clk);
    chk(!mdc, "R2", "mdc idle", mdc, 0);
    clkDiv = DIV_W'(div); isRead = rd; phyAddr = pa; regAddr = ra; wrData = wd;
    curRead = rd; phyVal = pv; riseCnt = 0; highCnt = 0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    n = 0; dones = 0; got = '0;
    while (busy && n < 2000) begin
      if (interject && n == 100) begin
        startReq = 1'b1; isRead = ~rd; phyAddr = ~pa; regAddr = ~ra;
        wrData = ~wd; clkDiv = DIV_W'(4);
      end else begin
        startReq = 1'b0;
      end
      @(negedge clk);
      n++;
      if (rdDone) begin dones++; got = rdData; end
    end
    startReq = 1'b0;
    chk(n == 64*div, "R2", "busy cycles", n, 64*div);
    chk(riseCnt == 64, "R2", "mdc periods", riseCnt, 64);
    chk(highCnt == 32*div, "R2", "mdc high cycles", highCnt, 32*div);
    chk(outB[63:32] == ef[63:32] && enB[63:32] == '1, "R3", "preamble",
        outB[63:32], ef[63:32]);
    chk(outB[31:30] == 2'b01 && enB[31:30] == 2'b11, "R3", "start pattern",
        outB[31:30], 2'b01);
    chk(outB[29:18] == ef[29:18] && enB[29:18] == '1, "R4", "opcode and addresses",
        outB[29:18], ef[29:18]);
    if (rd) begin
      chk(enB[17:0] == '0, "R6", "enable released", enB[17:0], 0);
      chk(dones == 1 && got == pv, "R7", "read data", {dones[15:0], got}, {16'd1, pv});
      lastRd = pv;
      if (ra == 5'd1) expLink = ~pv[2];
    end else begin
      chk(outB[17:0] == ef[17:0] && enB[17:0] == '1, "R5", "turnaround and data",
          outB[17:0], ef[17:0]);
      chk(dones == 0, "R7", "no done on write", dones, 0);
    end
    chk(rdData == lastRd, "R7", "rdData held", rdData, lastRd);
    chk(linkFail == expLink, "R9", "linkFail", linkFail, expLink);
    @(negedge clk);
    chk(!rdDone, "R7", "done one cycle", rdDone, 0);
    chk(!busy && !mdc, "R8", "no extra frame", {busy, mdc}, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; startReq = 1'b0; isRead = 1'b0; phyAddr = '0; regAddr = '0;
    wrData = '0; clkDiv = DIV_W'(4); mdiIn = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, mdc, mdoEn, mdoOut, rdDone, linkFail} == 6'b0 && rdData == 16'h0,
        "R1", "during reset", {busy, mdc, mdoEn, mdoOut, rdDone, linkFail, rdData}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, mdc, mdoEn, mdoOut, rdDone, linkFail} == 6'b0 && rdData == 16'h0,
        "R1", "after reset", {busy, mdc, mdoEn, mdoOut, rdDone, linkFail, rdData}, 0);

    // directed corner cases
    runFrame(1'b0, 5'h15, 5'h0A, 16'hA55A, 16'h0000, 4, 1'b0);    // R5 minimal divisor write
    runFrame(1'b1, 5'h01, 5'h01, 16'h0000, 16'h8001, 4, 1'b0);    // R9 link bit clear -> flag 1
    runFrame(1'b1, 5'h1F, 5'h03, 16'h0000, 16'hFFFF, 6, 1'b0);    // R9 other reg, flag kept
    runFrame(1'b0, 5'h00, 5'h01, 16'h0004, 16'h0000, 8, 1'b0);    // R9 write to reg 1, flag kept
    runFrame(1'b1, 5'h0C, 5'h01, 16'h0000, 16'h0004, 4, 1'b0);    // R9 link bit set -> flag 0
    runFrame(1'b1, 5'h11, 5'h06, 16'h1234, 16'h6C39, 8, 1'b1);    // R8 start while busy
    runFrame(1'b0, 5'h0E, 5'h1B, 16'h0F0F, 16'h0000, 10, 1'b1);   // R8 start while busy

    // random frames
    for (int i = 0; i < 20; i++) begin
      runFrame(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
               16'($urandom), 4 + 2 * int'($urandom % 4), 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule